// File: doc/BRIEF.md
# Dual Compare-And-Swap Unit

This block carries out one double compare-and-swap on two separate memory locations. It is started with a 12-bit register-select field, an operand size and two addresses. It takes a snapshot of four register-file values: two compare values and two update values. It reads both locations. It writes both update values back only when each loaded value equals its compare value. Throughout the memory sequence it holds a lock output, so that no other master can slip an access in between.

When the operation ends, the unit returns the loaded values to the two compare registers through two register-file write ports, and it pulses a done strobe. It also reports compare-style condition flags. The flags are taken from the first pair if that pair mismatched, and from the second pair otherwise. In word size only the low halves take part: the compare, the memory data and the register write-back all use the low 16 bits.

Top module: `dcas_unit`

## Requirements
- R1: The read indices come from `reg_sel`, which is sampled at start. The first compare register is bits 11:9, the second compare register is bits 8:6, the first update register is bits 5:3 and the second update register is bits 2:0. The indices stay on the read-index outputs until the next start.
- R2: Every operation begins with two reads (`mem_we`=0): first at `addr_a`, then at `addr_b`. Both reads happen even when the first pair already mismatches.
- R3: Both loaded values may equal their compare values. Only in that case do two writes follow: the first update value to `addr_a`, then the second update value to `addr_b`. In every other case exactly two accesses take place and memory is not written.
- R4: `cc_flags` is {N,Z,V,C} (bit 3 down to bit 0) of the subtraction loaded minus compare at the operand size. N is the sign bit of the difference. Z is set when the two are equal. V is signed overflow. C is the unsigned borrow. The pair used is the first pair when it mismatched, and the second pair otherwise. The flags are valid in the done cycle and held while the unit is idle.
- R5: In the done cycle, the first compare register is written with the value loaded from `addr_a` and the second compare register with the value loaded from `addr_b`. This happens whether or not the swap took place.
- R6: Word size is `size_long`=0 (`mem_long`=0). In this size only the low 16 bits of loaded and compare values are compared. Memory writes carry the update value's low 16 bits. Write-back uses byte-half enable 2'b01, with the register's original upper 16 bits on the data bus, so the upper half is kept. Longword size uses enable 2'b11 and full values.
- R7: `mem_lock` rises with the first read, stays high whenever `mem_req` is high, and falls after the acknowledge of the last access.
- R8: `done` is a single-cycle pulse, once per operation. A `start` that arrives while an operation is in progress is ignored.
- R9: The two compare fields may name the same register. In that case only port B writes, and the register ends up holding the value loaded from `addr_b`.
- R10: After a synchronous active-low reset, even one taken in the middle of an operation, `mem_req`, `mem_lock`, `done` and both write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| size_long | input | 1 | 1 = longword, 0 = word |
| reg_sel | input | 12 | Four 3-bit register selects |
| addr_a | input | ADDR_W | First memory address |
| addr_b | input | ADDR_W | Second memory address |
| rf_ridx_ca | output | 3 | Read index, first compare register |
| rf_ridx_cb | output | 3 | Read index, second compare register |
| rf_ridx_ua | output | 3 | Read index, first update register |
| rf_ridx_ub | output | 3 | Read index, second update register |
| rf_rdata_ca | input | DATA_W | Read data for rf_ridx_ca |
| rf_rdata_cb | input | DATA_W | Read data for rf_ridx_cb |
| rf_rdata_ua | input | DATA_W | Read data for rf_ridx_ua |
| rf_rdata_ub | input | DATA_W | Read data for rf_ridx_ub |
| rf_we_a | output | 1 | Write enable, port A (first compare register) |
| rf_widx_a | output | 3 | Write index, port A |
| rf_wdata_a | output | DATA_W | Write data, port A |
| rf_wbe_a | output | 2 | Half enables, port A (bit 0 low half, bit 1 high half) |
| rf_we_b | output | 1 | Write enable, port B (second compare register) |
| rf_widx_b | output | 3 | Write index, port B |
| rf_wdata_b | output | DATA_W | Write data, port B |
| rf_wbe_b | output | 2 | Half enables, port B |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_long | output | 1 | Access size, 1 = longword |
| mem_lock | output | 1 | Bus lock held across the sequence |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| cc_flags | output | 4 | {N,Z,V,C} |
| done | output | 1 | End-of-operation pulse |

## Verification
The assertions take three things for granted about the environment. `mem_ack` arrives only while `mem_req` is high. The register-file read data belongs to the indices the unit is driving at that moment. `start` may come at any time, busy or not. The bench memory acknowledges each request exactly once as a one-cycle pulse after a chosen latency, and it never acknowledges without a request. It returns filler in the upper half of word-size reads, so the low-half handling is actually tested. The register-file model answers combinationally from the driven indices. The bench also pulses `start` in the middle of an operation and applies reset during a locked sequence.

// File: rtl/dcas_pkg.sv
// Shared types for the dual compare-and-swap unit.
// Assumes a 12-bit select field made of four equal register indices.
package dcas_pkg;
    localparam int IDX_W   = 3;
    localparam int N_FIELD = 4;
    localparam int SEL_W   = IDX_W * N_FIELD;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RD_A,
        ST_RD_B,
        ST_WR_A,
        ST_WR_B,
        ST_FIN
    } dcas_state_e;
endpackage

// File: rtl/dcas_decode.sv
// Splits the register-select field into four indices.
// Field 0 is the most significant group (first compare register), field 3 the least.
module dcas_decode
    import dcas_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output logic [IDX_W-1:0] fld [N_FIELD]
);
    // One slice per field, taken from the top of the select word downward.
    for (genvar g = 0; g < N_FIELD; g++) begin : g_fld
        assign fld[g] = sel[(N_FIELD-g)*IDX_W-1 -: IDX_W];
    end
endmodule

// File: rtl/dcas_cmp.sv
// One compare pair: equality and {N,Z,V,C} of loaded minus expected at the operand size.
// Assumes word size means the low DATA_W/2 bits; upper bits are ignored in that size.
module dcas_cmp #(
    parameter int DATA_W = 32
) (
    input  logic              size_long,
    input  logic [DATA_W-1:0] loaded,
    input  logic [DATA_W-1:0] expected,
    output logic              equal,
    output logic [3:0]        nzvc
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] diff_l;
    logic [HALF_W-1:0] diff_w;
    logic [HALF_W-1:0] ld_w;
    logic [HALF_W-1:0] ex_w;

    // Differences at both sizes.
    always_comb begin
        ld_w   = loaded[HALF_W-1:0];
        ex_w   = expected[HALF_W-1:0];
        diff_l = loaded - expected;
        diff_w = ld_w - ex_w;
    end

    // Pick the result of the active size.
    always_comb begin
        if (size_long) begin
            equal = (loaded == expected);
            nzvc  = {diff_l[DATA_W-1],
                     (diff_l == '0),
                     (loaded[DATA_W-1] ^ expected[DATA_W-1]) & (diff_l[DATA_W-1] ^ loaded[DATA_W-1]),
                     (loaded < expected)};
        end else begin
            equal = (ld_w == ex_w);
            nzvc  = {diff_w[HALF_W-1],
                     (diff_w == '0),
                     (ld_w[HALF_W-1] ^ ex_w[HALF_W-1]) & (diff_w[HALF_W-1] ^ ld_w[HALF_W-1]),
                     (ld_w < ex_w)};
        end
    end
endmodule

// File: rtl/dcas_ctrl.sv
// Sequencer: snapshot, read A, read B, optional write A and B, finish.
// Assumes mem_ack is only given while a request is outstanding.
module dcas_ctrl
    import dcas_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        mem_ack,
    input  logic        swap_ok,
    output dcas_state_e st,
    output logic        latch_cmd,
    output logic        cap_rf,
    output logic        cap_la,
    output logic        cap_lb,
    output logic        in_rd_b,
    output logic        mem_req,
    output logic        mem_we,
    output logic        use_b,
    output logic        mem_lock,
    output logic        done
);
    dcas_state_e st_nxt;
    logic        lock_q;

    // Next-state selection.
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (start) st_nxt = ST_FETCH;
            ST_FETCH: st_nxt = ST_RD_A;
            ST_RD_A:  if (mem_ack) st_nxt = ST_RD_B;
            ST_RD_B:  if (mem_ack) st_nxt = swap_ok ? ST_WR_A : ST_FIN;
            ST_WR_A:  if (mem_ack) st_nxt = ST_WR_B;
            ST_WR_B:  if (mem_ack) st_nxt = ST_FIN;
            ST_FIN:   st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Lock: set on entry to the first read, cleared on the final acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b0;
        else if (st == ST_FETCH)
            lock_q <= 1'b1;
        else if (mem_ack && ((st == ST_RD_B && !swap_ok) || st == ST_WR_B))
            lock_q <= 1'b0;
    end

    // Strobes and bus controls decoded from the state.
    always_comb begin
        latch_cmd = (st == ST_IDLE) && start;
        cap_rf    = (st == ST_FETCH);
        cap_la    = (st == ST_RD_A) && mem_ack;
        cap_lb    = (st == ST_RD_B) && mem_ack;
        in_rd_b   = (st == ST_RD_B);
        mem_req   = (st == ST_RD_A) || (st == ST_RD_B) || (st == ST_WR_A) || (st == ST_WR_B);
        mem_we    = (st == ST_WR_A) || (st == ST_WR_B);
        use_b     = (st == ST_RD_B) || (st == ST_WR_B);
        done      = (st == ST_FIN);
        mem_lock  = lock_q;
    end
endmodule

// File: rtl/dcas_wback.sv
// Formats the two compare-register write-backs.
// Word size merges the loaded low half with the register's kept upper half;
// when both indices match, only port B writes so the second loaded value wins.
module dcas_wback
    import dcas_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                   size_long,
    input  logic                   fire,
    input  logic [IDX_W-1:0]       idx_a,
    input  logic [IDX_W-1:0]       idx_b,
    input  logic [DATA_W-1:0]      ld_a,
    input  logic [DATA_W-1:0]      ld_b,
    input  logic [DATA_W/2-1:0]    keep_a,
    input  logic [DATA_W/2-1:0]    keep_b,
    output logic                   we_a,
    output logic [DATA_W-1:0]      wdata_a,
    output logic [1:0]             wbe_a,
    output logic                   we_b,
    output logic [DATA_W-1:0]      wdata_b,
    output logic [1:0]             wbe_b
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] ld   [2];
    logic [HALF_W-1:0] keep [2];
    logic [DATA_W-1:0] dat  [2];

    assign ld[0]   = ld_a;
    assign ld[1]   = ld_b;
    assign keep[0] = keep_a;
    assign keep[1] = keep_b;

    // Per-port data: full value or merged low half.
    for (genvar p = 0; p < 2; p++) begin : g_port
        assign dat[p] = size_long ? ld[p] : {keep[p], ld[p][HALF_W-1:0]};
    end

    // Enables and half selects.
    always_comb begin
        we_a    = fire && (idx_a != idx_b);
        we_b    = fire;
        wdata_a = dat[0];
        wdata_b = dat[1];
        wbe_a   = size_long ? 2'b11 : 2'b01;
        wbe_b   = size_long ? 2'b11 : 2'b01;
    end
endmodule

// File: rtl/dcas_unit.sv
// Dual compare-and-swap unit top level.
// Snapshots operands, runs the locked four-access (or two-access) memory
// sequence, produces compare flags and writes loaded values to the compare registers.
// Assumes register-file reads are combinational from the index outputs.
module dcas_unit
    import dcas_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              size_long,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic [IDX_W-1:0]  rf_ridx_ca,
    output logic [IDX_W-1:0]  rf_ridx_cb,
    output logic [IDX_W-1:0]  rf_ridx_ua,
    output logic [IDX_W-1:0]  rf_ridx_ub,
    input  logic [DATA_W-1:0] rf_rdata_ca,
    input  logic [DATA_W-1:0] rf_rdata_cb,
    input  logic [DATA_W-1:0] rf_rdata_ua,
    input  logic [DATA_W-1:0] rf_rdata_ub,
    output logic              rf_we_a,
    output logic [IDX_W-1:0]  rf_widx_a,
    output logic [DATA_W-1:0] rf_wdata_a,
    output logic [1:0]        rf_wbe_a,
    output logic              rf_we_b,
    output logic [IDX_W-1:0]  rf_widx_b,
    output logic [DATA_W-1:0] rf_wdata_b,
    output logic [1:0]        rf_wbe_b,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_long,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [3:0]        cc_flags,
    output logic              done
);
    localparam int HALF_W = DATA_W / 2;

    dcas_state_e       st;
    logic              latch_cmd, cap_rf, cap_la, cap_lb, in_rd_b, use_b;
    logic              size_q;
    logic [SEL_W-1:0]  sel_q;
    logic [ADDR_W-1:0] addr_a_q, addr_b_q;
    logic [DATA_W-1:0] ca_q, cb_q, ua_q, ub_q;
    logic [DATA_W-1:0] la_q, lb_q;
    logic [IDX_W-1:0]  fld [N_FIELD];
    logic [DATA_W-1:0] upd;
    logic              swap_ok;
    logic [DATA_W-1:0] cmp_l [2];
    logic [DATA_W-1:0] cmp_c [2];
    logic              cmp_eq [2];
    logic [3:0]        cmp_f  [2];

    dcas_decode u_dec (
        .sel (sel_q),
        .fld (fld)
    );

    dcas_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mem_ack   (mem_ack),
        .swap_ok   (swap_ok),
        .st        (st),
        .latch_cmd (latch_cmd),
        .cap_rf    (cap_rf),
        .cap_la    (cap_la),
        .cap_lb    (cap_lb),
        .in_rd_b   (in_rd_b),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .use_b     (use_b),
        .mem_lock  (mem_lock),
        .done      (done)
    );

    // Command capture at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q   <= 1'b0;
            sel_q    <= '0;
            addr_a_q <= '0;
            addr_b_q <= '0;
        end else if (latch_cmd) begin
            size_q   <= size_long;
            sel_q    <= reg_sel;
            addr_a_q <= addr_a;
            addr_b_q <= addr_b;
        end
    end

    // Register-file snapshot of compare and update values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ca_q <= '0;
            cb_q <= '0;
            ua_q <= '0;
            ub_q <= '0;
        end else if (cap_rf) begin
            ca_q <= rf_rdata_ca;
            cb_q <= rf_rdata_cb;
            ua_q <= rf_rdata_ua;
            ub_q <= rf_rdata_ub;
        end
    end

    // Loaded values from the two reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            la_q <= '0;
            lb_q <= '0;
        end else begin
            if (cap_la) la_q <= mem_rdata;
            if (cap_lb) lb_q <= mem_rdata;
        end
    end

    // Compare inputs; the second loaded value is taken from the bus while it arrives.
    assign cmp_l[0] = la_q;
    assign cmp_l[1] = in_rd_b ? mem_rdata : lb_q;
    assign cmp_c[0] = ca_q;
    assign cmp_c[1] = cb_q;

    for (genvar p = 0; p < 2; p++) begin : g_cmp
        dcas_cmp #(.DATA_W(DATA_W)) u_cmp (
            .size_long (size_q),
            .loaded    (cmp_l[p]),
            .expected  (cmp_c[p]),
            .equal     (cmp_eq[p]),
            .nzvc      (cmp_f[p])
        );
    end

    // Swap decision and flag source selection.
    always_comb begin
        swap_ok  = cmp_eq[0] && cmp_eq[1];
        cc_flags = cmp_eq[0] ? cmp_f[1] : cmp_f[0];
    end

    // Memory bus data path.
    always_comb begin
        upd       = use_b ? ub_q : ua_q;
        mem_addr  = use_b ? addr_b_q : addr_a_q;
        mem_wdata = size_q ? upd : {{HALF_W{1'b0}}, upd[HALF_W-1:0]};
        mem_long  = size_q;
    end

    // Register-file read indices.
    always_comb begin
        rf_ridx_ca = fld[0];
        rf_ridx_cb = fld[1];
        rf_ridx_ua = fld[2];
        rf_ridx_ub = fld[3];
        rf_widx_a  = fld[0];
        rf_widx_b  = fld[1];
    end

    dcas_wback #(.DATA_W(DATA_W)) u_wb (
        .size_long (size_q),
        .fire      (done),
        .idx_a     (fld[0]),
        .idx_b     (fld[1]),
        .ld_a      (la_q),
        .ld_b      (lb_q),
        .keep_a    (ca_q[DATA_W-1:HALF_W]),
        .keep_b    (cb_q[DATA_W-1:HALF_W]),
        .we_a      (rf_we_a),
        .wdata_a   (rf_wdata_a),
        .wbe_a     (rf_wbe_a),
        .we_b      (rf_we_b),
        .wdata_b   (rf_wdata_b),
        .wbe_b     (rf_wbe_b)
    );
endmodule

// File: rtl/dcas_chk.sv
// Property checker for dcas_unit, attached by bind below.
// Assumes mem_ack only while mem_req is high.
module dcas_chk
    import dcas_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input dcas_state_e       st,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_lock,
    input logic              done,
    input logic              swap_ok,
    input logic              rf_we_a,
    input logic              rf_we_b,
    input logic [IDX_W-1:0]  rf_widx_a,
    input logic [IDX_W-1:0]  rf_widx_b,
    input logic [1:0]        rf_wbe_b,
    input logic              size_q,
    input logic [3:0]        cc_flags
);
    a_r7_lock_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);

    a_r2_first_access_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_lock) |-> (mem_req && !mem_we));

    a_r3_write_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> swap_ok);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_ports_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_a && rf_we_b) |-> (rf_widx_a != rf_widx_b));

    a_r6_word_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_b && !size_q) |-> (rf_wbe_b == 2'b01));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!mem_req && !mem_lock && !done && !rf_we_b));

    a_r4_flags_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && $past(st) == ST_IDLE) |-> $stable(cc_flags));
endmodule

bind dcas_unit dcas_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_lock  (mem_lock),
    .done      (done),
    .swap_ok   (swap_ok),
    .rf_we_a   (rf_we_a),
    .rf_we_b   (rf_we_b),
    .rf_widx_a (rf_widx_a),
    .rf_widx_b (rf_widx_b),
    .rf_wbe_b  (rf_wbe_b),
    .size_q    (size_q),
    .cc_flags  (cc_flags)
);

// File: tb/tb_dcas_unit.sv
module tb_dcas_unit;
    typedef struct packed {
        logic        lng;
        logic [11:0] sel;
        logic [31:0] ma;
        logic [31:0] mb;
        logic [31:0] vc1;
        logic [31:0] vc2;
        logic [31:0] vu1;
        logic [31:0] vu2;
        logic [1:0]  lat;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 12'o1234, 32'h1000_0000, 32'h2222_0000, 32'h1000_0000, 32'h2222_0000, 32'hAAAA_5555, 32'h1234_5678, 2'd0},
        '{1'b1, 12'o1234, 32'h0000_0005, 32'h0000_0009, 32'h0000_0007, 32'h0000_0009, 32'h0000_00AA, 32'h0000_00BB, 2'd1},
        '{1'b1, 12'o1234, 32'h0000_0042, 32'h8000_0000, 32'h0000_0042, 32'h0000_0001, 32'h0000_0011, 32'h0000_0022, 2'd2},
        '{1'b0, 12'o5670, 32'hFFFF_1234, 32'h0000_8000, 32'h9999_1234, 32'h7777_8000, 32'h5555_BEEF, 32'hCCCC_0001, 2'd1},
        '{1'b0, 12'o5670, 32'h0000_0001, 32'h3333_0007, 32'h1111_0002, 32'h2222_0007, 32'h0000_0F0F, 32'h0000_0E0E, 2'd0},
        '{1'b0, 12'o5670, 32'h0000_0010, 32'h0000_8000, 32'h4444_0010, 32'h5555_0001, 32'h0000_0101, 32'h0000_0202, 2'd3},
        '{1'b1, 12'o3456, 32'h0001_1234, 32'h0000_0003, 32'h0002_1234, 32'h0000_0003, 32'h0000_0077, 32'h0000_0088, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        size_long = 1'b1;
    logic [11:0] reg_sel = '0;
    logic [31:0] addr_a = '0, addr_b = '0;
    logic [2:0]  rf_ridx_ca, rf_ridx_cb, rf_ridx_ua, rf_ridx_ub;
    logic [31:0] rf_rdata_ca, rf_rdata_cb, rf_rdata_ua, rf_rdata_ub;
    logic        rf_we_a, rf_we_b;
    logic [2:0]  rf_widx_a, rf_widx_b;
    logic [31:0] rf_wdata_a, rf_wdata_b;
    logic [1:0]  rf_wbe_a, rf_wbe_b;
    logic        mem_req, mem_we, mem_long, mem_lock;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [3:0]  cc_flags;
    logic        done;

    logic [31:0] rf  [8];
    logic [31:0] mem [16];
    int          lat = 0;
    int          acc_cnt = 0;
    logic [3:0]  acc_addr [8];
    logic        acc_we   [8];
    logic        lock_bad = 1'b0;
    int          done_cnt = 0;
    logic [3:0]  flags_at_done = '0;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    assign rf_rdata_ca = rf[rf_ridx_ca];
    assign rf_rdata_cb = rf[rf_ridx_cb];
    assign rf_rdata_ua = rf[rf_ridx_ua];
    assign rf_rdata_ub = rf[rf_ridx_ub];

    dcas_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .size_long(size_long), .reg_sel(reg_sel),
        .addr_a(addr_a), .addr_b(addr_b),
        .rf_ridx_ca(rf_ridx_ca), .rf_ridx_cb(rf_ridx_cb), .rf_ridx_ua(rf_ridx_ua), .rf_ridx_ub(rf_ridx_ub),
        .rf_rdata_ca(rf_rdata_ca), .rf_rdata_cb(rf_rdata_cb), .rf_rdata_ua(rf_rdata_ua), .rf_rdata_ub(rf_rdata_ub),
        .rf_we_a(rf_we_a), .rf_widx_a(rf_widx_a), .rf_wdata_a(rf_wdata_a), .rf_wbe_a(rf_wbe_a),
        .rf_we_b(rf_we_b), .rf_widx_b(rf_widx_b), .rf_wdata_b(rf_wdata_b), .rf_wbe_b(rf_wbe_b),
        .mem_req(mem_req), .mem_we(mem_we), .mem_long(mem_long), .mem_lock(mem_lock),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .cc_flags(cc_flags), .done(done)
    );

    // Memory responder: one-cycle ack after lat idle cycles; word reads carry filler above bit 15.
    initial begin
        int wait_cnt;
        wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_req && !mem_lock) lock_bad = 1'b1;
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wait_cnt < lat) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    mem_ack = 1'b1;
                    if (acc_cnt < 8) begin
                        acc_addr[acc_cnt] = mem_addr[3:0];
                        acc_we[acc_cnt]   = mem_we;
                    end
                    acc_cnt++;
                    if (mem_we) begin
                        if (mem_long) mem[mem_addr[3:0]] = mem_wdata;
                        else          mem[mem_addr[3:0]][15:0] = mem_wdata[15:0];
                    end else begin
                        mem_rdata = mem_long ? mem[mem_addr[3:0]] : {16'hA5A5, mem[mem_addr[3:0]][15:0]};
                    end
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    // Register-file write model: port A then port B, honouring half enables.
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                done_cnt++;
                flags_at_done = cc_flags;
            end
            if (rf_we_a) begin
                if (rf_wbe_a[0]) rf[rf_widx_a][15:0]  = rf_wdata_a[15:0];
                if (rf_wbe_a[1]) rf[rf_widx_a][31:16] = rf_wdata_a[31:16];
            end
            if (rf_we_b) begin
                if (rf_wbe_b[0]) rf[rf_widx_b][15:0]  = rf_wdata_b[15:0];
                if (rf_wbe_b[1]) rf[rf_widx_b][31:16] = rf_wdata_b[31:16];
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_flags(input logic lng, input logic [31:0] l, input logic [31:0] c);
        logic [31:0] d;
        logic [15:0] dw;
        d  = l - c;
        dw = l[15:0] - c[15:0];
        if (lng)
            return {d[31], d == 32'h0, (l[31] != c[31]) && (d[31] != l[31]), l < c};
        else
            return {dw[15], dw == 16'h0, (l[15] != c[15]) && (dw[15] != l[15]), l[15:0] < c[15:0]};
    endfunction

    // One full operation with preload, run and result checks.
    task automatic run_op(input string tag, input logic lng, input logic [11:0] sel,
                          input logic [3:0] aa, input logic [3:0] ab,
                          input logic [31:0] ma, input logic [31:0] mb,
                          input logic [31:0] vc1, input logic [31:0] vc2,
                          input logic [31:0] vu1, input logic [31:0] vu2,
                          input int l, input bit extra_start);
        logic [2:0]  ica, icb, iua, iub;
        logic [31:0] pc1, pc2, pu1, pu2, msk, l1, l2, e_ma, e_mb;
        logic [31:0] r [8];
        logic        eq1, eq2, ok;
        logic [3:0]  ef;
        int          d0, guard;
        ica = sel[11:9]; icb = sel[8:6]; iua = sel[5:3]; iub = sel[2:0];
        @(negedge clk);
        for (int i = 0; i < 8; i++) rf[i] = 32'h0BAD_0000 + i;
        rf[ica] = vc1; rf[icb] = vc2; rf[iua] = vu1; rf[iub] = vu2;
        mem[aa] = ma; mem[ab] = mb;
        pc1 = rf[ica]; pc2 = rf[icb]; pu1 = rf[iua]; pu2 = rf[iub];
        for (int i = 0; i < 8; i++) r[i] = rf[i];
        msk = lng ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        l1 = ma & msk; l2 = mb & msk;
        eq1 = (l1 == (pc1 & msk)); eq2 = (l2 == (pc2 & msk)); ok = eq1 && eq2;
        ef  = !eq1 ? exp_flags(lng, l1, pc1) : exp_flags(lng, l2, pc2);
        e_ma = !ok ? ma : (lng ? pu1 : {ma[31:16], pu1[15:0]});
        e_mb = !ok ? mb : (lng ? pu2 : {mb[31:16], pu2[15:0]});
        r[ica] = lng ? l1 : {pc1[31:16], l1[15:0]};
        r[icb] = lng ? l2 : {pc2[31:16], l2[15:0]};
        acc_cnt = 0; lock_bad = 1'b0; lat = l; d0 = done_cnt;
        start = 1'b1; size_long = lng; reg_sel = sel;
        addr_a = {28'h0, aa}; addr_b = {28'h0, ab};
        @(negedge clk);
        start = 1'b0;
        if (extra_start) begin
            @(negedge clk); @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (done_cnt == d0 && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        repeat (6) @(negedge clk);
        chk({tag, " R1 read indices"}, {20'h0, rf_ridx_ca, rf_ridx_cb, rf_ridx_ua, rf_ridx_ub}, {20'h0, sel});
        chk({tag, " R2 read order"}, {24'h0, acc_we[0], acc_addr[0], 1'b0, acc_we[1], acc_addr[1]},
            {24'h0, 1'b0, aa, 1'b0, 1'b0, ab});
        chk({tag, " R3 access count"}, acc_cnt, ok ? 4 : 2);
        if (ok)
            chk({tag, " R3 write order"}, {24'h0, acc_we[2], acc_addr[2], 1'b0, acc_we[3], acc_addr[3]},
                {24'h0, 1'b1, aa, 1'b0, 1'b1, ab});
        chk({tag, " R3 memory A"}, mem[aa], e_ma);
        chk({tag, " R3 memory B"}, mem[ab], e_mb);
        chk({tag, " R4 flags at done"}, {28'h0, flags_at_done}, {28'h0, ef});
        chk({tag, " R4 flags held idle"}, {28'h0, cc_flags}, {28'h0, ef});
        chk({tag, " R5 first compare reg"}, rf[ica], r[ica]);
        chk({tag, " R5 second compare reg"}, rf[icb], r[icb]);
        if (!lng)
            chk({tag, " R6 upper half kept"}, {16'h0, rf[ica][31:16]}, {16'h0, pc1[31:16]});
        chk({tag, " R7 lock held and released"}, {31'h0, lock_bad | mem_lock}, 32'h0);
        chk({tag, " R8 one done pulse"}, done_cnt - d0, 1);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        for (int i = 0; i < 8; i++) rf[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset outputs quiet", {27'h0, mem_req, mem_lock, done, rf_we_a, rf_we_b}, 32'h0);

        for (int v = 0; v < NVEC; v++)
            run_op($sformatf("vec%0d", v), VEC[v].lng, VEC[v].sel, 4'd3, 4'd12,
                   VEC[v].ma, VEC[v].mb, VEC[v].vc1, VEC[v].vc2, VEC[v].vu1, VEC[v].vu2,
                   int'(VEC[v].lat), 1'b0);

        // R9: both compare fields name register 2; second loaded value must remain.
        run_op("same_cmp_reg", 1'b1, 12'o2234, 4'd5, 4'd6, 32'h11, 32'h22, 32'h11, 32'h11,
               32'h33, 32'h44, 0, 1'b0);
        chk("R9 shared compare register", rf[2], 32'h22);

        // R8: a start during a busy operation does not launch a second one.
        run_op("busy_start", 1'b1, 12'o1234, 4'd7, 4'd8, 32'h5, 32'h6, 32'h5, 32'h6,
               32'h77, 32'h88, 2, 1'b1);
        repeat (10) @(negedge clk);
        chk("R8 no second operation", acc_cnt, 4);

        // R2 with addresses swapped in value order.
        run_op("swapped_addr", 1'b1, 12'o4567, 4'd14, 4'd1, 32'hCAFE, 32'hF00D, 32'hCAFE, 32'hF00D,
               32'h1, 32'h2, 1, 1'b0);

        // R10: reset in the middle of a locked sequence.
        lat = 3;
        @(negedge clk);
        start = 1'b1; size_long = 1'b1; reg_sel = 12'o1234;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 lock high mid sequence", {31'h0, mem_lock}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 reset mid operation", {29'h0, mem_req, mem_lock, done}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 idle after reset", {29'h0, mem_req, mem_lock, done}, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule